// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a bus-attached signed divide unit. Software loads a 64-bit dividend and a 64-bit divisor through a plain 32-bit register port, one half-word of 32 bits at a time. It also picks an operand-width mode in a control word. Any write to the control word or to an operand half starts a new division at once. A busy flag in the control word stays high until the quotient and remainder registers are updated.

The datapath is a radix-2 restoring divider that works on magnitudes and fixes the signs at the end. Its latency is the same in every mode. Two cases produce fixed results and raise an error flag:
- a divisor that is zero after mode adjustment;
- the most negative 64-bit dividend divided by minus one.

A write that arrives while a division is running discards that division and starts over with the current register contents.

Top module: `int_div_regs`

## Requirements
- R1: After reset every register reads zero, including busy (control bit 15), error (control bit 14) and mode (control bits [1:0]).
- R2: Any write to the control, dividend or divisor word sets busy from the next cycle. Busy clears, and the results appear, exactly 66 cycles after the clock edge that took the last such write (OP_W + 2), in every mode.
- R3: Word addresses are as follows. 0 is control. 1 and 2 are the dividend low and high halves, 3 and 4 the divisor halves, 5 and 6 the quotient halves, 7 and 8 the remainder halves. A control write stores only bits [1:0]. Writes to the quotient and remainder addresses are ignored and start nothing. Reads of addresses 9 to 15 return zero.
- R4: Mode 0 sign-extends both operands from their low 32 bits. Modes 1 and 3 sign-extend only the divisor from its low 32 bits. Mode 2 uses both operands at full 64 bits.
- R5: A normal division gives a quotient truncated toward zero and a remainder carrying the sign of the dividend, and it clears the error flag.
- R6: When the effective divisor is zero, the remainder gets the effective dividend. The quotient is 1 if that dividend is negative and 0 otherwise, and the error flag is set.
- R7: When the effective dividend is the most negative 64-bit value and the divisor is -1, the quotient gets the dividend unchanged, the remainder keeps its previous value, and the error flag is set.
- R8: A trigger write during a running division aborts it. The result then corresponds only to the register contents after the last write.
- R9: While busy, the quotient and remainder registers read back their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Word address of the read |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |

## Verification
The assertions check several rules on every cycle:
- a trigger write raises busy;
- an accepted completion drops busy;
- the result registers stay frozen while busy and under writes to result addresses;
- the remainder is kept on the overflow case;
- the running partial remainder stays below the divisor magnitude.

The values themselves can only be shown by the bench's scenarios, which compare against a behavioural model. These cover the sign-extension of each mode, truncation and remainder sign, the zero-divisor and overflow results, abort on rewrite, and the exact 66-cycle latency.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef enum logic [1:0] {
    MODE_W32_W32 = 2'd0,
    MODE_W64_W32 = 2'd1,
    MODE_W64_W64 = 2'd2,
    MODE_W64_W32_ALT = 2'd3
  } div_mode_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_NUM_LO = 1;
  localparam int unsigned REG_NUM_HI = 2;
  localparam int unsigned REG_DEN_LO = 3;
  localparam int unsigned REG_DEN_HI = 4;
  localparam int unsigned REG_QUO_LO = 5;
  localparam int unsigned REG_QUO_HI = 6;
  localparam int unsigned REG_REM_LO = 7;
  localparam int unsigned REG_REM_HI = 8;

  localparam int unsigned BUSY_BIT = 15;
  localparam int unsigned ERR_BIT  = 14;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import int_div_pkg::*;
#(
  parameter int unsigned OP_W = 64
) (
  input  logic [1:0]      mode_i,
  input  logic [OP_W-1:0] num_raw_i,
  input  logic [OP_W-1:0] den_raw_i,
  output logic [OP_W-1:0] num_eff_o,
  output logic [OP_W-1:0] den_eff_o
);
  localparam int unsigned HALF = OP_W / 2;

  function automatic logic [OP_W-1:0] sext_half(input logic [OP_W-1:0] x);
    return {{(OP_W-HALF){x[HALF-1]}}, x[HALF-1:0]};
  endfunction

  always_comb begin
    num_eff_o = num_raw_i;
    den_eff_o = sext_half(den_raw_i);
    case (div_mode_e'(mode_i))
      MODE_W32_W32: num_eff_o = sext_half(num_raw_i);
      MODE_W64_W64: den_eff_o = den_raw_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned OP_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] num_i,
  input  logic [OP_W-1:0] den_i,
  output logic            done_o,
  output logic [OP_W-1:0] quo_o,
  output logic [OP_W-1:0] rem_o,
  output logic            rem_we_o,
  output logic            err_o
);
  localparam int unsigned CNT_W = $clog2(OP_W);
  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(OP_W - 1);
  localparam logic [OP_W-1:0]  MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  rem_q, sh_q, dmag_q, num_q;
  logic             num_neg_q, quo_neg_q, zero_q, ovf_q;

  logic [OP_W:0]    shifted;
  logic [OP_W+1:0]  diff;
  logic             take;
  logic [OP_W-1:0]  nmag, dmag;

  assign shifted = {rem_q, sh_q[OP_W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, dmag_q};
  assign take    = ~diff[OP_W+1];
  assign nmag    = num_i[OP_W-1] ? -num_i : num_i;
  assign dmag    = den_i[OP_W-1] ? -den_i : den_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      sh_q      <= '0;
      dmag_q    <= '0;
      num_q     <= '0;
      num_neg_q <= 1'b0;
      quo_neg_q <= 1'b0;
      zero_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (start_i) begin
      run_q     <= 1'b1;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      sh_q      <= nmag;
      dmag_q    <= dmag;
      num_q     <= num_i;
      num_neg_q <= num_i[OP_W-1];
      quo_neg_q <= num_i[OP_W-1] ^ den_i[OP_W-1];
      zero_q    <= (den_i == '0);
      ovf_q     <= (num_i == MOST_NEG) && (den_i == '1);
    end else if (run_q) begin
      rem_q <= take ? diff[OP_W-1:0] : shifted[OP_W-1:0];
      sh_q  <= {sh_q[OP_W-2:0], take};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_IT) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  // Special cases take precedence over the iterated result
  always_comb begin
    rem_we_o = 1'b1;
    err_o    = 1'b0;
    quo_o    = quo_neg_q ? -sh_q : sh_q;
    rem_o    = num_neg_q ? -rem_q : rem_q;
    if (zero_q) begin
      err_o = 1'b1;
      quo_o = {{(OP_W-1){1'b0}}, num_neg_q};
      rem_o = num_q;
    end else if (ovf_q) begin
      err_o    = 1'b1;
      quo_o    = num_q;
      rem_we_o = 1'b0;
    end
  end

  assign done_o = done_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !zero_q) |-> (rem_q < dmag_q)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R2
endmodule

// File: rtl/int_div_regs.sv
module int_div_regs
  import int_div_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0]  rd_data_o
);
  localparam int unsigned OP_W = 2 * BUS_W;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_NUM_LO = ADDR_W'(REG_NUM_LO);
  localparam logic [ADDR_W-1:0] A_NUM_HI = ADDR_W'(REG_NUM_HI);
  localparam logic [ADDR_W-1:0] A_DEN_LO = ADDR_W'(REG_DEN_LO);
  localparam logic [ADDR_W-1:0] A_DEN_HI = ADDR_W'(REG_DEN_HI);
  localparam logic [ADDR_W-1:0] A_QUO_LO = ADDR_W'(REG_QUO_LO);
  localparam logic [ADDR_W-1:0] A_QUO_HI = ADDR_W'(REG_QUO_HI);
  localparam logic [ADDR_W-1:0] A_REM_LO = ADDR_W'(REG_REM_LO);
  localparam logic [ADDR_W-1:0] A_REM_HI = ADDR_W'(REG_REM_HI);

  logic [1:0]      mode_q;
  logic            busy_q, err_q, start_q;
  logic [OP_W-1:0] num_q, den_q, quo_q, rem_q;

  logic [OP_W-1:0] num_eff, den_eff, core_quo, core_rem;
  logic            core_done, core_rem_we, core_err;
  logic            trig_wr, abort, accept, res_wr;

  assign trig_wr = wr_en_i && (wr_addr_i == A_CTRL   || wr_addr_i == A_NUM_LO ||
                               wr_addr_i == A_NUM_HI || wr_addr_i == A_DEN_LO ||
                               wr_addr_i == A_DEN_HI);
  assign res_wr  = wr_en_i && (wr_addr_i == A_QUO_LO || wr_addr_i == A_QUO_HI ||
                               wr_addr_i == A_REM_LO || wr_addr_i == A_REM_HI);
  // A completion racing a new trigger belongs to a stale operation
  assign abort   = trig_wr || start_q;
  assign accept  = core_done && !abort;

  div_operand_prep #(.OP_W(OP_W)) u_prep (
    .mode_i    (mode_q),
    .num_raw_i (num_q),
    .den_raw_i (den_q),
    .num_eff_o (num_eff),
    .den_eff_o (den_eff)
  );

  div_core #(.OP_W(OP_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_q),
    .num_i    (num_eff),
    .den_i    (den_eff),
    .done_o   (core_done),
    .quo_o    (core_quo),
    .rem_o    (core_rem),
    .rem_we_o (core_rem_we),
    .err_o    (core_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      num_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
    end else begin
      start_q <= trig_wr;
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CTRL:   mode_q <= wr_data_i[1:0];
          A_NUM_LO: num_q[BUS_W-1:0]    <= wr_data_i;
          A_NUM_HI: num_q[OP_W-1:BUS_W] <= wr_data_i;
          A_DEN_LO: den_q[BUS_W-1:0]    <= wr_data_i;
          A_DEN_HI: den_q[OP_W-1:BUS_W] <= wr_data_i;
          default: ;
        endcase
      end
      if (trig_wr) begin
        busy_q <= 1'b1;
      end else if (accept) begin
        busy_q <= 1'b0;
        err_q  <= core_err;
        quo_q  <= core_quo;
        if (core_rem_we) rem_q <= core_rem;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[BUSY_BIT] = busy_q;
        rd_data_o[ERR_BIT]  = err_q;
        rd_data_o[1:0]      = mode_q;
      end
      A_NUM_LO: rd_data_o = num_q[BUS_W-1:0];
      A_NUM_HI: rd_data_o = num_q[OP_W-1:BUS_W];
      A_DEN_LO: rd_data_o = den_q[BUS_W-1:0];
      A_DEN_HI: rd_data_o = den_q[OP_W-1:BUS_W];
      A_QUO_LO: rd_data_o = quo_q[BUS_W-1:0];
      A_QUO_HI: rd_data_o = quo_q[OP_W-1:BUS_W];
      A_REM_LO: rd_data_o = rem_q[BUS_W-1:0];
      A_REM_HI: rd_data_o = rem_q[OP_W-1:BUS_W];
      default: ;
    endcase
  end

  AST_WR_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr |=> busy_q); // R2
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !busy_q); // R2
  AST_OVF_KEEPS_REM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !core_rem_we) |=> $stable(rem_q)); // R7
  AST_BUSY_HOLDS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !accept) |=> ($stable(quo_q) && $stable(rem_q))); // R9
  AST_RESULT_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_wr && !accept) |=> ($stable(quo_q) && $stable(rem_q))); // R3
endmodule

// File: tb/sim_int_div_regs.sv
module sim_int_div_regs;
  localparam int unsigned LAT = 66;
  localparam logic [63:0] MOST_NEG = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int errs = 0;
  int checks = 0;
  longint unsigned cyc = 0;
  longint unsigned last_wr = 0;
  logic [63:0] m_quo = '0, m_rem = '0;

  typedef struct {
    logic [63:0] quo;
    logic [63:0] rem;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // 4000 ps period, 250 MHz
  always #2000 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int_div_regs u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #100;
    d = rd_data;
  endtask

  task automatic rd64(input logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    last_wr = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [63:0] sx(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  task automatic model(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                       output logic [63:0] q, output logic [63:0] r, output logic e);
    longint sn, sd;
    sn = (m == 2'd0) ? longint'(sx(n)) : longint'(n);
    sd = (m == 2'd2) ? longint'(d) : longint'(sx(d));
    if (sd == 0) begin
      q = (sn < 0) ? 64'd1 : 64'd0;
      r = sn;
      e = 1'b1;
    end else if (sn == longint'(MOST_NEG) && sd == -1) begin
      q = sn;
      r = m_rem;
      e = 1'b1;
    end else begin
      q = sn / sd;
      r = sn % sd;
      e = 1'b0;
    end
  endtask

  task automatic push(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                      input string tag);
    exp_t it;
    model(m, n, d, it.quo, it.rem, it.err);
    it.tag = tag;
    m_quo = it.quo;
    m_rem = it.rem;
    sb.push_back(it);
  endtask

  task automatic wait_drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                    input string tag);
    wr(4'd0, {30'd0, m});
    wr(4'd1, n[31:0]);
    wr(4'd2, n[63:32]);
    wr(4'd3, d[31:0]);
    wr(4'd4, d[63:32]);
    push(m, n, d, tag);
    wait_drain();
  endtask

  // Monitor: on each busy fall, pop and compare
  initial begin
    logic prev_busy;
    logic [31:0] c;
    logic [63:0] q, r;
    exp_t it;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      #100;
      if (rst_n) begin
        rd(4'd0, c);
        if (prev_busy && !c[15]) begin
          if (sb.size() == 0) begin
            check("R8 unexpected completion", 64'd1, 64'd0);
          end else begin
            it = sb.pop_front();
            rd64(4'd5, q);
            rd64(4'd7, r);
            check({it.tag, " quotient"}, q, it.quo);
            check({it.tag, " remainder"}, r, it.rem);
            check({it.tag, " error flag"}, {63'd0, c[14]}, {63'd0, it.err});
            check({it.tag, " R2 latency"}, 64'(cyc - last_wr), 64'(LAT));
          end
        end
        prev_busy = c[15];
      end
    end
  end

  initial begin
    #(64'd4000 * 64'd200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d32;
    logic [63:0] d64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1000;
    rd(4'd0, d32); check("R1 ctrl after reset", 64'(d32), 64'd0);
    rd64(4'd1, d64); check("R1 dividend after reset", d64, 64'd0);
    rd64(4'd5, d64); check("R1 quotient after reset", d64, 64'd0);
    rd64(4'd7, d64); check("R1 remainder after reset", d64, 64'd0);
    @(negedge clk);

    // R5: full-width normal divisions, all sign combinations
    op(2'd2, 64'd100, 64'd7, "R5 +/+");
    op(2'd2, -64'sd100, 64'd7, "R5 -/+");
    op(2'd2, 64'd100, -64'sd7, "R5 +/-");
    op(2'd2, -64'sd100, -64'sd7, "R5 -/-");
    op(2'd2, 64'h7FFF_1234_5678_9ABC, 64'h0000_0003_0000_0011, "R5 wide");
    op(2'd2, MOST_NEG, 64'd3, "R5 most negative / 3");

    // R4: operand-width modes, garbage in upper halves
    op(2'd0, 64'hDEAD_0000_FFFF_FFF6, 64'h1234_5678_0000_0003, "R4 mode0");
    op(2'd1, 64'h0000_0001_0000_0000, 64'hABCD_0000_FFFF_FFFE, "R4 mode1");
    op(2'd3, 64'hFFFF_FFF0_0000_0001, 64'h0000_0005_0000_0007, "R4 mode3");
    op(2'd2, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, "R4 mode2");

    // R6: zero divisor
    op(2'd2, 64'd55, 64'd0, "R6 zero den pos");
    op(2'd2, -64'sd55, 64'd0, "R6 zero den neg");
    op(2'd0, 64'h0000_0007_8000_0000, 64'h0000_0009_0000_0000, "R6 mode0 low zero");

    // R7: overflow keeps remainder; then R5 clears error
    op(2'd2, 64'd10, 64'd4, "R5 before overflow");
    op(2'd2, MOST_NEG, 64'hFFFF_FFFF_FFFF_FFFF, "R7 overflow mode2");
    op(2'd1, MOST_NEG, 64'h0000_0000_FFFF_FFFF, "R7 overflow mode1");
    op(2'd2, 64'd9, 64'd2, "R5 error cleared");

    // R9: results hold their previous values while busy
    wr(4'd0, 32'd2);
    wr(4'd1, 32'd1000);
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd33);
    wr(4'd4, 32'd0);
    push(2'd2, 64'd1000, 64'd33, "R9 result after busy");
    #1000;
    rd(4'd0, d32); check("R9 busy during op", 64'(d32[15]), 64'd1);
    rd64(4'd5, d64); check("R9 quotient held while busy", d64, 64'd4);
    rd64(4'd7, d64); check("R9 remainder held while busy", d64, 64'd1);
    @(negedge clk);
    wait_drain();

    // R8: rewrite mid-operation aborts the old division
    wr(4'd0, 32'd2);
    wr(4'd1, 32'd77);
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd5);
    wr(4'd4, 32'd0);
    repeat (20) @(negedge clk);
    wr(4'd3, 32'd9);
    push(2'd2, 64'd77, 64'd9, "R8 abort");
    wait_drain();

    // R3: result writes ignored, ctrl stores only mode, unmapped reads zero
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
    #1000;
    rd(4'd0, d32); check("R3 result write starts nothing", 64'(d32[15]), 64'd0);
    rd64(4'd5, d64); check("R3 quotient write ignored", d64, 64'd8);
    rd64(4'd7, d64); check("R3 remainder write ignored", d64, 64'd5);
    rd(4'd9, d32); check("R3 unmapped 9 reads zero", 64'(d32), 64'd0);
    rd(4'd15, d32); check("R3 unmapped 15 reads zero", 64'(d32), 64'd0);
    @(negedge clk);
    wr(4'd0, 32'hFFFF_3FF3);
    push(2'd3, 64'd77, 64'd9, "R3 ctrl write mode 3");
    #1000;
    rd(4'd0, d32); check("R3 ctrl stores only mode", 64'({d32[15], d32[1:0]}), 64'h7);
    @(negedge clk);
    wait_drain();
    rd(4'd0, d32); check("R3 ctrl mode readback", 64'(d32[1:0]), 64'd3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule